// File: doc/BRIEF.md
# Class-Ranked Issue Queue

This block holds instructions whose source operands are already available and decides which of them an out-of-order core sends to execution next. Each arriving entry brings a tag, a program sequence number and a two-bit class. The queue keeps every entry in sorted position. The primary key is class rank: long-latency first, then memory and control sharing one rank, then regular. The secondary key is age inside a rank, where the oldest instruction comes first. Because of this, an instruction that has waited in a priority class can never be passed by a regular instruction that arrives later.

Age is measured wrap-aware. The design subtracts the core's oldest in-flight sequence number from each sequence number, modulo the sequence width, and compares the results. The head of the queue is presented on issue slot 0, and the following entries are presented on the slots after it. When the consumer raises `issue_en`, every valid slot leaves the queue at the clock edge. In the same edge, one new entry may be inserted into its sorted position among the entries that remain.

An occupancy state machine has three states: `OCC_EMPTY`, `OCC_PART` and `OCC_FULL`. It drives the flags and the insert handshake. Its transitions are:
- `OCC_EMPTY` to `OCC_PART` on an accepted insert.
- `OCC_PART` to `OCC_FULL` when the next occupancy reaches DEPTH.
- `OCC_PART` to `OCC_EMPTY` when the next occupancy is zero or on a flush.
- `OCC_FULL` to `OCC_PART` when issue frees space.
- `OCC_FULL` to `OCC_EMPTY` on a flush.

In every other case the state holds.

Top module: `rq_class_queue`

## Requirements
- R1: Class encoding on `ins_cls`/`iss_cls` is 0 regular, 1 memory, 2 control, 3 long-latency. The queue presents any long-latency entry ahead of every memory or control entry, and any memory or control entry ahead of every regular entry.
- R2: Within one rank, entries appear in ascending age order, oldest at slot 0. An entry whose age equals that of a queued entry goes behind it.
- R3: Memory and control entries share a single rank and are ordered between themselves by age only.
- R4: A regular entry inserted while a priority entry is queued is placed behind that priority entry, even when its sequence number is older.
- R5: Issue slot k has `iss_valid[k]` high exactly when the occupancy exceeds k. Valid slots are always a contiguous run starting at slot 0. With `issue_en` high, all valid slots leave at that clock edge.
- R6: An insert is accepted at a clock edge when `ins_valid` and `ins_ready` are both high, and it is visible on the issue slots after that edge. An insert and an issue in the same edge are both performed: the new entry is sorted among the entries that remain.
- R7: `flush` empties the queue at the next clock edge. It overrides any insert or issue in that cycle.
- R8: `full` is high exactly when the queue holds DEPTH entries, and `ins_ready` is then low. An insert offered while full is dropped. `empty` is high exactly when the queue holds no entry.
- R9: After reset the queue is empty, with `empty` high, `full` low, `ins_ready` high and no issue slot valid.
- R10: Age is (seq - `oldest_seq`) modulo 2^SEQ_W. This means a sequence number that has wrapped past zero ranks as younger than one just below the wrap point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all entries |
| oldest_seq | input | SEQ_W | Oldest in-flight sequence number, the base for age |
| ins_valid | input | 1 | Insert request |
| ins_ready | output | 1 | Queue can accept an insert |
| ins_tag | input | TAG_W | Tag of the inserted entry |
| ins_seq | input | SEQ_W | Sequence number of the inserted entry |
| ins_cls | input | 2 | Class of the inserted entry |
| issue_en | input | 1 | Consumer takes all valid issue slots |
| iss_valid | output | ISSUE_W | Per-slot valid |
| iss_tag | output | ISSUE_W*TAG_W | Slot tags, slot k at bits k*TAG_W upward |
| iss_seq | output | ISSUE_W*SEQ_W | Slot sequence numbers |
| iss_cls | output | ISSUE_W*2 | Slot classes |
| full | output | 1 | Queue holds DEPTH entries |
| empty | output | 1 | Queue holds no entry |

## Verification
Every result is due one clock edge after its stimulus:
- An accepted insert, an issue or a flush shows on the slots, the flags and `ins_ready` right after the edge that takes it.
- The flags and slot valids then depend only on stored state.

The bench drives inputs on the falling edge. It samples on the next falling edge, half a period after the capturing edge, so every check sees exactly one register update. The ordering checks read slot 0 and slot 1 after each insert or issue. Cases deeper than two entries are confirmed by issuing repeatedly and reading each new head.

// File: rtl/rq_pkg.sv
package rq_pkg;

    typedef enum logic [1:0] {
        CLS_REG  = 2'd0,
        CLS_MEM  = 2'd1,
        CLS_CTRL = 2'd2,
        CLS_LONG = 2'd3
    } rq_cls_e;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } rq_occ_e;

    // Higher value issues first; memory and control share a level.
    function automatic logic [1:0] cls_rank(input logic [1:0] cls);
        unique case (rq_cls_e'(cls))
            CLS_LONG: cls_rank = 2'd2;
            CLS_MEM,
            CLS_CTRL: cls_rank = 2'd1;
            default:  cls_rank = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/rq_before.sv
// Strict precedence test: high when entry A must sit ahead of entry B.
module rq_before #(
    parameter int SEQ_W = 6
) (
    input  logic [1:0]       a_cls,
    input  logic [SEQ_W-1:0] a_seq,
    input  logic [1:0]       b_cls,
    input  logic [SEQ_W-1:0] b_seq,
    input  logic [SEQ_W-1:0] base_seq,
    output logic             a_first
);
    import rq_pkg::*;

    logic [1:0]       a_rank, b_rank;
    logic [SEQ_W-1:0] a_age, b_age;

    always_comb begin
        a_rank  = cls_rank(a_cls);
        b_rank  = cls_rank(b_cls);
        a_age   = a_seq - base_seq;
        b_age   = b_seq - base_seq;
        a_first = (a_rank > b_rank) || ((a_rank == b_rank) && (a_age < b_age));
    end
endmodule

// File: rtl/rq_pop_shift.sv
// Moves every entry toward the head by the number of entries issued.
module rq_pop_shift #(
    parameter int DEPTH   = 8,
    parameter int ENT_W   = 14,
    parameter int ISSUE_W = 2,
    parameter int CNT_W   = 4
) (
    input  logic [DEPTH-1:0][ENT_W-1:0] din,
    input  logic [CNT_W-1:0]            shift_n,
    output logic [DEPTH-1:0][ENT_W-1:0] dout
);
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            dout[i] = '0;
            for (int s = 0; s <= ISSUE_W; s++) begin
                if ((shift_n == CNT_W'(s)) && (i + s < DEPTH)) begin
                    dout[i] = din[i + s];
                end
            end
        end
    end
endmodule

// File: rtl/rq_class_queue.sv
module rq_class_queue #(
    parameter int DEPTH   = 8,
    parameter int ISSUE_W = 2,
    parameter int TAG_W   = 6,
    parameter int SEQ_W   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic [SEQ_W-1:0]         oldest_seq,
    input  logic                     ins_valid,
    output logic                     ins_ready,
    input  logic [TAG_W-1:0]         ins_tag,
    input  logic [SEQ_W-1:0]         ins_seq,
    input  logic [1:0]               ins_cls,
    input  logic                     issue_en,
    output logic [ISSUE_W-1:0]       iss_valid,
    output logic [ISSUE_W*TAG_W-1:0] iss_tag,
    output logic [ISSUE_W*SEQ_W-1:0] iss_seq,
    output logic [ISSUE_W*2-1:0]     iss_cls,
    output logic                     full,
    output logic                     empty
);
    import rq_pkg::*;

    localparam int ENT_W = TAG_W + SEQ_W + 2;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int SEQ_LO = 2;
    localparam int TAG_LO = SEQ_W + 2;

    logic [DEPTH-1:0][ENT_W-1:0] ent_q, ent_sh, ent_d;
    logic [CNT_W-1:0]            cnt_q, cnt_d, pop_n, left_n, ins_pos;
    logic [DEPTH-1:0]            new_first;
    logic [ENT_W-1:0]            new_ent;
    logic                        push;
    rq_occ_e                     occ_q, occ_d;

    // Issue count and accepted insert
    always_comb begin
        if (issue_en) begin
            pop_n = (cnt_q > CNT_W'(ISSUE_W)) ? CNT_W'(ISSUE_W) : cnt_q;
        end else begin
            pop_n = '0;
        end
        left_n  = cnt_q - pop_n;
        push    = ins_valid && ins_ready;
        new_ent = {ins_tag, ins_seq, ins_cls};
    end

    rq_pop_shift #(
        .DEPTH  (DEPTH),
        .ENT_W  (ENT_W),
        .ISSUE_W(ISSUE_W),
        .CNT_W  (CNT_W)
    ) u_shift (
        .din    (ent_q),
        .shift_n(pop_n),
        .dout   (ent_sh)
    );

    // One comparator per surviving slot against the incoming entry
    for (genvar j = 0; j < DEPTH; j++) begin : g_cmp
        rq_before #(.SEQ_W(SEQ_W)) u_cmp (
            .a_cls   (ins_cls),
            .a_seq   (ins_seq),
            .b_cls   (ent_sh[j][1:0]),
            .b_seq   (ent_sh[j][SEQ_LO +: SEQ_W]),
            .base_seq(oldest_seq),
            .a_first (new_first[j])
        );
    end

    // Sorted array: the number of survivors that stay ahead gives the slot
    always_comb begin
        ins_pos = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if ((CNT_W'(j) < left_n) && !new_first[j]) begin
                ins_pos = ins_pos + CNT_W'(1);
            end
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i == 0) begin : g_head
            always_comb begin
                if (push && (ins_pos == '0)) ent_d[i] = new_ent;
                else                         ent_d[i] = ent_sh[i];
            end
        end else begin : g_body
            always_comb begin
                if (!push || (CNT_W'(i) < ins_pos)) ent_d[i] = ent_sh[i];
                else if (CNT_W'(i) == ins_pos)      ent_d[i] = new_ent;
                else                                ent_d[i] = ent_sh[i - 1];
            end
        end
    end

    always_comb begin
        if (flush) cnt_d = '0;
        else       cnt_d = left_n + CNT_W'(push);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            cnt_q <= '0;
            ent_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            ent_q <= ent_d;
        end
    end

    // Occupancy state machine: next state
    always_comb begin
        occ_d = occ_q;
        unique case (occ_q)
            OCC_EMPTY: begin
                if (push && !flush) occ_d = (cnt_d == CNT_W'(DEPTH)) ? OCC_FULL : OCC_PART;
            end
            OCC_PART: begin
                if (flush || cnt_d == '0)          occ_d = OCC_EMPTY;
                else if (cnt_d == CNT_W'(DEPTH))   occ_d = OCC_FULL;
            end
            OCC_FULL: begin
                if (flush || cnt_d == '0)          occ_d = OCC_EMPTY;
                else if (cnt_d != CNT_W'(DEPTH))   occ_d = OCC_PART;
            end
            default: occ_d = OCC_EMPTY;
        endcase
    end

    // Occupancy state register
    always_ff @(posedge clk) begin
        if (!rst_n) occ_q <= OCC_EMPTY;
        else        occ_q <= occ_d;
    end

    // Outputs
    always_comb begin
        full      = 1'b0;
        empty     = 1'b0;
        unique case (occ_q)
            OCC_EMPTY: empty = 1'b1;
            OCC_PART:  ;
            OCC_FULL:  full  = 1'b1;
            default:   empty = 1'b1;
        endcase
        ins_ready = !full;
    end

    for (genvar k = 0; k < ISSUE_W; k++) begin : g_iss
        assign iss_valid[k]               = (cnt_q > CNT_W'(k));
        assign iss_tag[k*TAG_W +: TAG_W]  = ent_q[k][TAG_LO +: TAG_W];
        assign iss_seq[k*SEQ_W +: SEQ_W]  = ent_q[k][SEQ_LO +: SEQ_W];
        assign iss_cls[k*2 +: 2]          = ent_q[k][1:0];
    end
endmodule

// File: rtl/rq_class_queue_chk.sv
module rq_class_queue_chk #(
    parameter int ISSUE_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush,
    input logic               ins_valid,
    input logic               ins_ready,
    input logic [ISSUE_W-1:0] iss_valid,
    input logic [ISSUE_W*2-1:0] iss_cls,
    input logic               full,
    input logic               empty
);
    import rq_pkg::*;

    for (genvar k = 0; k + 1 < ISSUE_W; k++) begin : g_pair
        AST_RANK_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[k+1] |-> (cls_rank(iss_cls[k*2 +: 2]) >= cls_rank(iss_cls[(k+1)*2 +: 2]))); // R1
        AST_SLOT_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[k+1] |-> iss_valid[k]); // R5
    end

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !ins_ready); // R8
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty)); // R8
    AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (iss_valid == '0)); // R8
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && iss_valid == '0)); // R7
    AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_ready && !flush) |=> !empty); // R6
endmodule

bind rq_class_queue rq_class_queue_chk #(.ISSUE_W(ISSUE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .ins_valid(ins_valid),
    .ins_ready(ins_ready),
    .iss_valid(iss_valid),
    .iss_cls  (iss_cls),
    .full     (full),
    .empty    (empty)
);

// File: tb/sim_rq_class_queue.sv
`timescale 1ns/1ps
module sim_rq_class_queue;
    localparam int DEPTH = 8, ISSUE_W = 2, TAG_W = 6, SEQ_W = 6;

    logic clk = 0, rst_n = 0, flush = 0, ins_valid = 0, issue_en = 0;
    logic [SEQ_W-1:0] oldest_seq = '0, ins_seq = '0;
    logic [TAG_W-1:0] ins_tag = '0;
    logic [1:0] ins_cls = '0;
    logic ins_ready, full, empty;
    logic [ISSUE_W-1:0] iss_valid;
    logic [ISSUE_W*TAG_W-1:0] iss_tag;
    logic [ISSUE_W*SEQ_W-1:0] iss_seq;
    logic [ISSUE_W*2-1:0] iss_cls;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    rq_class_queue #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W), .TAG_W(TAG_W), .SEQ_W(SEQ_W)) u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .oldest_seq(oldest_seq),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_tag(ins_tag),
        .ins_seq(ins_seq), .ins_cls(ins_cls), .issue_en(issue_en),
        .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_seq(iss_seq),
        .iss_cls(iss_cls), .full(full), .empty(empty));

    task automatic chk(input int act, input int exp, input string req, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int tag_at(input int k);
        return int'(iss_tag[k*TAG_W +: TAG_W]);
    endfunction

    task automatic push(input int tag, input int seq, input int cls);
        ins_valid = 1; ins_tag = TAG_W'(tag); ins_seq = SEQ_W'(seq); ins_cls = 2'(cls);
        @(negedge clk);
        ins_valid = 0;
    endtask

    task automatic pop1;
        issue_en = 1;
        @(negedge clk);
        issue_en = 0;
    endtask

    task automatic drain;
        while (!empty) pop1();
    endtask

    task automatic t_reset;
        chk(int'(empty), 1, "R9", "empty after reset");
        chk(int'(full), 0, "R9", "full after reset");
        chk(int'(ins_ready), 1, "R9", "ready after reset");
        chk(int'(iss_valid), 0, "R9", "valid after reset");
    endtask

    task automatic t_class_order;
        push(1, 1, 0); push(2, 5, 1); push(3, 7, 3); push(4, 3, 2);
        chk(tag_at(0), 3, "R1", "long-latency at head");
        chk(tag_at(1), 4, "R3", "control seq3 before memory seq5");
        pop1();
        chk(tag_at(0), 2, "R3", "memory after control");
        chk(tag_at(1), 1, "R1", "regular last");
        chk(int'(iss_valid), 3, "R5", "two slots valid");
        pop1();
        chk(int'(empty), 1, "R5", "empty after two issues");
        chk(int'(iss_valid), 0, "R5", "no valid when empty");
    endtask

    task automatic t_late_regular;
        push(10, 20, 1); push(11, 2, 0);
        chk(tag_at(0), 10, "R4", "priority stays ahead of older regular");
        chk(tag_at(1), 11, "R4", "late regular behind");
        drain();
    endtask

    task automatic t_regular_age;
        push(21, 9, 0); push(22, 4, 0); push(23, 6, 0); push(24, 6, 0);
        chk(tag_at(0), 22, "R2", "oldest regular first");
        chk(tag_at(1), 23, "R2", "next regular");
        pop1();
        chk(tag_at(0), 24, "R2", "equal age goes behind");
        chk(tag_at(1), 21, "R2", "youngest last");
        pop1();
        chk(int'(empty), 1, "R5", "drained");
    endtask

    task automatic t_wrap;
        oldest_seq = SEQ_W'(60);
        push(31, 2, 0); push(32, 62, 0);
        chk(tag_at(0), 32, "R10", "pre-wrap seq older");
        chk(tag_at(1), 31, "R10", "wrapped seq younger");
        drain();
        oldest_seq = '0;
    endtask

    task automatic t_full;
        for (int i = 0; i < DEPTH; i++) push(40 + i, i, 0);
        chk(int'(full), 1, "R8", "full at DEPTH");
        chk(int'(ins_ready), 0, "R8", "not ready when full");
        push(50, 0, 3);
        chk(tag_at(0), 40, "R8", "insert while full dropped");
        for (int p = 0; p < DEPTH / ISSUE_W; p++) begin
            chk(tag_at(0), 40 + p * ISSUE_W, "R5", "head after issue");
            chk(int'(ins_ready), p == 0 ? 0 : 1, "R6", "ready follows occupancy");
            pop1();
        end
        chk(int'(empty), 1, "R8", "empty after all issued");
    endtask

    task automatic t_same_cycle;
        push(60, 1, 0); push(61, 2, 0); push(62, 3, 0);
        issue_en = 1;
        push(63, 9, 3);
        issue_en = 0;
        chk(tag_at(0), 63, "R6", "insert sorted with issue");
        chk(tag_at(1), 62, "R6", "survivor behind");
        chk(int'(iss_valid), 3, "R6", "occupancy two");
        drain();
    endtask

    task automatic t_flush;
        push(5, 1, 0); push(6, 2, 1); push(7, 3, 3);
        flush = 1; issue_en = 1;
        push(8, 4, 3);
        flush = 0; issue_en = 0;
        chk(int'(empty), 1, "R7", "flush empties");
        chk(int'(iss_valid), 0, "R7", "no slot after flush");
        push(9, 5, 0);
        chk(tag_at(0), 9, "R7", "insert works after flush");
        drain();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_class_order();
        t_late_regular();
        t_regular_age();
        t_wrap();
        t_full();
        t_same_cycle();
        t_flush();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule